// File: doc/BRIEF.md
# Set-Propagate-Reset Prefix Carry Adder

This block adds two N-bit unsigned operands with no carry-in and returns an (N+1)-bit result. It has no clock and holds no state, so the sum follows the operands combinationally. Each bit position is first classified into one of three carry elements. A position where both operand bits are 1 *sets* the carry. A position where exactly one bit is 1 *propagates* the carry from below. A position where both bits are 0 *resets* the carry. Under the combining rule, a sequence of these elements reduces to its last set or reset, or to propagate if it holds neither.

The carry into each position is the prefix product of all lower positions. The positions are grouped into aligned power-of-two intervals, which are the nodes of a complete binary tree. Each interval gets two flags. The propagate flag is one wide AND. The set flag is a wide OR of AND terms. Every prefix is a chain of at most log2 N such intervals, taken from the binary digits of its length, and it is resolved with one more OR of AND terms. No carry ripples from one position to the next.

Top module: `spr_prefix_adder`

## Requirements
- R1: For every pair of operands, `sum` equals `op_a + op_b` zero-extended to N+1 bits.
- R2: The elements are encoded as follows: set is 2'b10 (both bits 1), propagate is 2'b01 (one bit 1) and reset is 2'b00 (both bits 0). The code 2'b11 is never formed. A set position i forces the carry into position i+1 to 1, and a reset position forces it to 0, whatever the lower positions hold.
- R3: The carry into position i+1 is 1 exactly when the highest-numbered position among 0..i that is not propagate is a set position. A prefix made only of propagate positions gives carry 0.
- R4: There is no carry-in. `sum[0]` equals `op_a[0] ^ op_b[0]`. Operands that are bitwise complements of each other give all ones in the low N bits and 0 in the top bit.
- R5: For each i below N, `sum[i]` equals `op_a[i] ^ op_b[i]` XOR the carry into position i.
- R6: `sum[N]` is the carry out of position N-1. All-ones plus all-ones gives 2^(N+1)-2, and all-ones plus 1 gives 2^N.
- R7: The construction is generic in N. With N = 8 the result is correct for all 65536 operand pairs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | N | First unsigned operand |
| op_b | input | N | Second unsigned operand |
| sum | output | N+1 | Unsigned sum; the top bit is the carry out |

## Verification
The checks are immediate assertions on a purely combinational path. They assume that both operands are fully known, with no X or Z bits, whenever the logic settles. They also assume that an intermediate state between two operand updates is never mistaken for a result. To keep within this, the bench sets every operand to a defined value from time zero onward. It changes the operands only at a rising clock edge and reads `sum` half a period later. The bench reads the internal carries through the ports only, as `sum ^ op_a ^ op_b`, and compares them with a scan for the last non-propagate position below each bit.

// File: rtl/spr_pkg.sv
package spr_pkg;

  typedef enum logic [1:0] {
    EL_RESET = 2'b00,
    EL_PROP  = 2'b01,
    EL_SET   = 2'b10
  } spr_elem_e;

  // Classify one bit position from its two operand bits.
  function automatic spr_elem_e spr_classify(input logic a, input logic b);
    if (a && b)      return EL_SET;
    else if (a || b) return EL_PROP;
    else             return EL_RESET;
  endfunction

  // Product of an earlier element with a later one.
  function automatic spr_elem_e spr_combine(input spr_elem_e early, input spr_elem_e late);
    return (late == EL_PROP) ? early : late;
  endfunction

  // Result bit from operand bits and incoming carry.
  function automatic logic spr_sum_bit(input logic a, input logic b, input logic cin);
    return a ^ b ^ cin;
  endfunction

endpackage

// File: rtl/spr_encode.sv
module spr_encode
  import spr_pkg::*;
#(
  parameter int N = 16
) (
  input  logic [N-1:0]      op_a,
  input  logic [N-1:0]      op_b,
  output logic [N-1:0][1:0] elem,
  output logic [N-1:0]      is_set,
  output logic [N-1:0]      is_prop
);

  for (genvar i = 0; i < N; i++) begin : g_bit
    assign elem[i]    = spr_classify(op_a[i], op_b[i]);
    assign is_set[i]  = (elem[i] == EL_SET);
    assign is_prop[i] = (elem[i] == EL_PROP);
  end

endmodule

// File: rtl/spr_interval_tree.sv
module spr_interval_tree #(
  parameter int LG = 4,
  localparam int NP = 1 << LG
) (
  input  logic [NP-1:0]        is_set,
  input  logic [NP-1:0]        is_prop,
  output logic [LG:0][NP-1:0]  iv_set,
  output logic [LG:0][NP-1:0]  iv_prop
);

  // Level lv holds NP>>lv aligned intervals of width 2**lv.
  for (genvar lv = 0; lv <= LG; lv++) begin : g_lvl
    localparam int W = 1 << lv;
    for (genvar k = 0; k < NP; k++) begin : g_idx
      if (k < (NP >> lv)) begin : g_node
        localparam int B = k * W;
        logic [W-1:0] term;
        for (genvar j = 0; j < W; j++) begin : g_term
          if (j == W - 1) begin : g_last
            assign term[j] = is_set[B+j];
          end else begin : g_mid
            assign term[j] = is_set[B+j] & (&is_prop[B+W-1:B+j+1]);
          end
        end
        assign iv_set[lv][k]  = |term;
        assign iv_prop[lv][k] = &is_prop[B+W-1:B];
      end else begin : g_none
        assign iv_set[lv][k]  = 1'b0;
        assign iv_prop[lv][k] = 1'b0;
      end
    end
  end

endmodule

// File: rtl/spr_prefix_combine.sv
module spr_prefix_combine #(
  parameter int N  = 16,
  parameter int LG = 4,
  localparam int NP = 1 << LG
) (
  input  logic [LG:0][NP-1:0] iv_set,
  input  logic [LG:0][NP-1:0] iv_prop,
  output logic [N-1:0]        pre_set
);

  logic unused_iv;
  assign unused_iv = ^{iv_set, iv_prop};

  // Prefix of positions 0..i has length L; each set bit b of L picks one
  // interval at level b, lower positions first (high bits of L first).
  for (genvar i = 0; i < N; i++) begin : g_pre
    localparam int L = i + 1;
    logic [LG:0] sel_s;
    logic [LG:0] sel_p;
    logic [LG:0] tm;
    for (genvar b = 0; b <= LG; b++) begin : g_sel
      localparam int IDX = (L >> (b + 1)) << 1;
      if (((L >> b) & 1) == 1) begin : g_use
        assign sel_s[b] = iv_set[b][IDX];
        assign sel_p[b] = iv_prop[b][IDX];
      end else begin : g_skip
        assign sel_s[b] = 1'b0;
        assign sel_p[b] = 1'b1;
      end
      if (b == 0) begin : g_t0
        assign tm[b] = sel_s[b];
      end else begin : g_tn
        assign tm[b] = sel_s[b] & (&sel_p[b-1:0]);
      end
    end
    logic unused_top;
    assign unused_top = sel_p[LG];
    assign pre_set[i] = |tm;
  end

endmodule

// File: rtl/spr_prefix_adder.sv
module spr_prefix_adder
  import spr_pkg::*;
#(
  parameter int N = 16
) (
  input  logic [N-1:0] op_a,
  input  logic [N-1:0] op_b,
  output logic [N:0]   sum
);

  localparam int LG = (N > 1) ? $clog2(N) : 1;
  localparam int NP = 1 << LG;

  logic [N-1:0][1:0]     elem;
  logic [N-1:0]          is_set;
  logic [N-1:0]          is_prop;
  logic [NP-1:0]         set_pad;
  logic [NP-1:0]         prop_pad;
  logic [LG:0][NP-1:0]   iv_set;
  logic [LG:0][NP-1:0]   iv_prop;
  logic [N-1:0]          pre_set;
  logic [N:0]            carry;

  spr_encode #(.N(N)) u_encode (
    .op_a    (op_a),
    .op_b    (op_b),
    .elem    (elem),
    .is_set  (is_set),
    .is_prop (is_prop)
  );

  if (NP > N) begin : g_pad
    assign set_pad  = {{(NP-N){1'b0}}, is_set};
    assign prop_pad = {{(NP-N){1'b0}}, is_prop};
  end else begin : g_nopad
    assign set_pad  = is_set;
    assign prop_pad = is_prop;
  end

  spr_interval_tree #(.LG(LG)) u_tree (
    .is_set  (set_pad),
    .is_prop (prop_pad),
    .iv_set  (iv_set),
    .iv_prop (iv_prop)
  );

  spr_prefix_combine #(.N(N), .LG(LG)) u_combine (
    .iv_set  (iv_set),
    .iv_prop (iv_prop),
    .pre_set (pre_set)
  );

  // Empty prefix is reset: no carry into bit 0.
  assign carry[0]   = 1'b0;
  assign carry[N:1] = pre_set;

  for (genvar i = 0; i < N; i++) begin : g_sum
    assign sum[i] = spr_sum_bit(op_a[i], op_b[i], carry[i]);
  end
  assign sum[N] = carry[N];

endmodule

// File: rtl/spr_prefix_adder_chk.sv
module spr_prefix_adder_chk #(
  parameter int N = 16
) (
  input logic [N-1:0]      op_a,
  input logic [N-1:0]      op_b,
  input logic [N:0]        sum,
  input logic [N-1:0][1:0] elem,
  input logic [N:0]        carry
);

  always_comb begin
    for (int i = 0; i < N; i++) begin
      // R2: code 2'b11 never formed
      assert_legal_code_R2: assert (elem[i] != 2'b11)
        else $error("illegal element code at position %0d", i);
      // R3: prefix-network carry agrees with a ripple recurrence
      assert_ripple_match_R3: assert (carry[i+1] ==
        ((op_a[i] & op_b[i]) | ((op_a[i] ^ op_b[i]) & carry[i])))
        else $error("carry into %0d disagrees with ripple", i + 1);
    end
    assert_no_carry_in_R4: assert (sum[0] == (op_a[0] ^ op_b[0]))
      else $error("bit 0 saw a carry-in");
    assert_total_sum_R1: assert (sum == ({1'b0, op_a} + {1'b0, op_b}))
      else $error("sum mismatch");
  end

endmodule

bind spr_prefix_adder spr_prefix_adder_chk #(.N(N)) u_chk (
  .op_a  (op_a),
  .op_b  (op_b),
  .sum   (sum),
  .elem  (elem),
  .carry (carry)
);

// File: tb/spr_prefix_adder_bench.sv
module spr_prefix_adder_bench;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic [15:0] a16 = '0;
  logic [15:0] b16 = '0;
  logic [16:0] s16;
  logic [7:0]  a8 = '0;
  logic [7:0]  b8 = '0;
  logic [8:0]  s8;

  int n_chk = 0;
  int n_bad = 0;
  logic done = 1'b0;

  spr_prefix_adder #(.N(16)) u_spr_prefix_adder (.op_a(a16), .op_b(b16), .sum(s16));
  spr_prefix_adder #(.N(8))  u_spr_prefix_adder_n8 (.op_a(a8), .op_b(b8), .sum(s8));

  localparam int NT = 12;
  localparam logic [15:0] TA [NT] = '{16'h0000, 16'hFFFF, 16'hFFFF, 16'hAAAA,
                                      16'h5555, 16'hAAAA, 16'h8000, 16'h00FF,
                                      16'h1234, 16'hFF00, 16'h7FFF, 16'hF0F0};
  localparam logic [15:0] TB [NT] = '{16'h0000, 16'hFFFF, 16'h0001, 16'h5555,
                                      16'h5555, 16'hAAAA, 16'h8000, 16'h0001,
                                      16'h4321, 16'h00FF, 16'h0001, 16'h0F10};
  localparam logic [16:0] TE [NT] = '{17'h00000, 17'h1FFFE, 17'h10000, 17'h0FFFF,
                                      17'h0AAAA, 17'h15554, 17'h10000, 17'h00100,
                                      17'h05555, 17'h0FFFF, 17'h08000, 17'h10000};

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Carry into position i from a scan for the last non-propagate below i.
  function automatic logic exp_carry(input logic [15:0] a, input logic [15:0] b, input int i);
    for (int j = i - 1; j >= 0; j--) begin
      if (a[j] && b[j]) return 1'b1;
      if (!a[j] && !b[j]) return 1'b0;
    end
    return 1'b0;
  endfunction

  task automatic apply16(input logic [15:0] a, input logic [15:0] b);
    @(posedge clk);
    a16 = a;
    b16 = b;
    @(negedge clk);
  endtask

  task automatic carry_checks(input logic [15:0] a, input logic [15:0] b);
    logic [16:0] c;
    c = s16 ^ {1'b0, a} ^ {1'b0, b};
    for (int i = 0; i <= 16; i++) begin
      check("R3 carry", {31'd0, c[i]}, {31'd0, exp_carry(a, b, i)});
    end
    for (int i = 0; i < 16; i++) begin
      check("R5 sum bit", {31'd0, s16[i]}, {31'd0, a[i] ^ b[i] ^ exp_carry(a, b, i)});
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 idle zero", {15'd0, s16}, 32'd0);

    for (int t = 0; t < NT; t++) begin
      apply16(TA[t], TB[t]);
      check("R1 table", {15'd0, s16}, {15'd0, TE[t]});
    end

    // R6: carry out
    apply16(16'hFFFF, 16'hFFFF);
    check("R6 ones+ones", {15'd0, s16}, 32'h1FFFE);
    apply16(16'hFFFF, 16'h0001);
    check("R6 ones+1", {31'd0, s16[16]}, 32'd1);

    // R4: complements and no carry-in
    apply16(16'h3C5A, 16'hC3A5);
    check("R4 complement", {15'd0, s16}, 32'h0FFFF);
    apply16(16'h0001, 16'h0001);
    check("R4 lsb", {31'd0, s16[0]}, 32'd0);

    // R2: a set or reset position decides the next carry regardless of below
    for (int i = 1; i < 16; i++) begin
      logic [15:0] low;
      logic [16:0] c;
      low = (16'h1 << i) - 16'h1;
      apply16((16'h1 << i) | (16'h0 & low), (16'h1 << i));
      c = s16 ^ {1'b0, a16} ^ {1'b0, b16};
      check("R2 set wins", {31'd0, c[i+1]}, 32'd1);
      apply16(low, low);
      c = s16 ^ {1'b0, a16} ^ {1'b0, b16};
      check("R2 reset wins", {31'd0, c[i+1]}, 32'd0);
    end

    // R3/R5 patterns including all-propagate prefix
    apply16(16'hAAAA, 16'h5555); carry_checks(16'hAAAA, 16'h5555);
    apply16(16'hFFFF, 16'hFFFF); carry_checks(16'hFFFF, 16'hFFFF);
    apply16(16'hA5A5, 16'h5A5A); carry_checks(16'hA5A5, 16'h5A5A);

    // R1 random
    for (int r = 0; r < 1000; r++) begin
      logic [15:0] ra, rb;
      ra = 16'($urandom);
      rb = 16'($urandom);
      apply16(ra, rb);
      check("R1 random", {15'd0, s16}, 32'(ra) + 32'(rb));
      if (r < 50) carry_checks(ra, rb);
    end

    // R7 exhaustive N=8
    for (int x = 0; x < 256; x++) begin
      for (int y = 0; y < 256; y++) begin
        @(posedge clk);
        a8 = x[7:0];
        b8 = y[7:0];
        @(negedge clk);
        check("R7 exhaustive", {23'd0, s8}, 32'(x + y));
      end
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule